// File: doc/BRIEF.md
# Free-Running Timer with Buffered Input Capture

This block is a 16-bit up-counter that advances on a qualifying tick. Around it sit two compare registers and four capture registers. The CPU reaches all of them through a byte-wide synchronous register bus. Four external capture pins pass through synchronizers and programmable edge detectors. Each detected edge stores the current count and raises an event flag. The seven event flags live in one status byte. Software clears a flag with a handshake: it must first read the flag as 1, and only then does a write of 0 clear it.

Channels A and B can run in buffered mode. In that mode, a new capture first pushes the previous capture into capture register C (for A) or D (for B) and then loads the fresh count. Software therefore gets the last two event times of one pin. Bit 0 of the status byte makes the counter restart from zero whenever it equals compare register A, which turns the timer into a programmable-period counter. An interrupt request output combines the flags with a per-flag enable mask.

Address map: 0x00/0x01 counter high/low, 0x02/0x03 compare A, 0x04/0x05 compare B, 0x06/0x07 capture A, 0x08/0x09 capture B, 0x0A/0x0B capture C, 0x0C/0x0D capture D, 0x0E status, 0x0F control, 0x10 interrupt enable. Even addresses hold the high byte. The counter and capture registers are read-only. The compare registers reset to 0xFFFF.

Top module: `frt_capture_timer`

## Requirements
- R1: After reset the status byte reads 0x00, the counter reads 0x0000, the capture registers read 0x0000, the compare registers read 0xFFFF and `irq_o` is 0.
- R2: The counter increases by one for each clock cycle in which `tick_i` is 1 and holds its value otherwise.
- R3: A tick at count 0xFFFF returns the counter to 0x0000 and sets the overflow flag (status bit 1). This does not apply when the compare-clear of R5 fires on that tick.
- R4: A tick while the counter equals compare A sets status bit 3. A tick while it equals compare B sets status bit 2.
- R5: When status bit 0 is 1, a tick while the counter equals compare A loads 0 instead of incrementing. Bit 0 is plain read/write storage.
- R6: Status bits 7..1 are set only by hardware events. A CPU write of 1 to any of them changes nothing.
- R7: A flag clears only when a CPU write of 0 to its bit follows a status read that returned it as 1. A write of 0 without that read leaves the flag at 1. After a clear, another read is needed before the next clear.
- R8: If a hardware set and a CPU clear target the same flag in the same cycle, the flag stays 1.
- R9: Control bits 5..2 choose the capture edge for pins A..D (bit 2 = A): 1 means rising and 0 means falling. A qualifying edge stores the counter into that pin's capture register and sets its flag: A bit 7, B bit 6, C bit 5, D bit 4. An edge of the other polarity does nothing.
- R10: Control bit 0 (channel A) and bit 1 (channel B) enable buffered mode. In that mode a capture moves the old A (or B) value into C (or D) before loading the count. A pin-C (or pin-D) edge then still sets its flag but leaves capture register C (or D) unchanged.
- R11: `irq_o` is 1 exactly when some status bit 7..1 is 1 and the same bit of the interrupt-enable register (0x10, bits 7..1) is 1.
- R12: While `standby_i` is 1 the whole status byte, bit 0 included, is forced to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby entry; clears the status byte |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| addr_i | input | 5 | Register byte address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_i`, 0 otherwise |
| cap_pin_i | input | 4 | Capture pins, bit 0 = A ... bit 3 = D |
| irq_o | output | 1 | Interrupt request |

## Verification
Every capture pin is driven through both edge polarities under both edge selections. This tells a correct polarity decode apart from a swapped or ignored one, and a correct pin-to-register mapping from a crossed one. The counter is run through a complete 16-bit wrap and then through a sweep of compare-clear periods. The bench predicts each count arithmetically, which separates the wrap, match and clear rules. The flag handshake is exercised with a write without a prior read, a write of 1, a clear after a read, and a clear that collides with a fresh event. Buffered mode is tested with two successive captures and a competing pin-C edge, which shows whether history is shifted or overwritten.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 5;
    localparam int N_CAP  = 4;
    localparam int N_FLAG = 7;
    localparam int CTRL_W = 2 + N_CAP;

    localparam logic [ADDR_W-1:0] A_CNT_H  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CNT_L  = 5'h01;
    localparam logic [ADDR_W-1:0] A_CMPA_H = 5'h02;
    localparam logic [ADDR_W-1:0] A_CMPA_L = 5'h03;
    localparam logic [ADDR_W-1:0] A_CMPB_H = 5'h04;
    localparam logic [ADDR_W-1:0] A_CMPB_L = 5'h05;
    localparam logic [ADDR_W-1:0] A_CAPA_H = 5'h06;
    localparam logic [ADDR_W-1:0] A_CAPA_L = 5'h07;
    localparam logic [ADDR_W-1:0] A_CAPB_H = 5'h08;
    localparam logic [ADDR_W-1:0] A_CAPB_L = 5'h09;
    localparam logic [ADDR_W-1:0] A_CAPC_H = 5'h0A;
    localparam logic [ADDR_W-1:0] A_CAPC_L = 5'h0B;
    localparam logic [ADDR_W-1:0] A_CAPD_H = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CAPD_L = 5'h0D;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h0E;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h0F;
    localparam logic [ADDR_W-1:0] A_IEN    = 5'h10;

    // flag vector index (status bit = index + 1)
    localparam int F_OVF = 0;
    localparam int F_CMB = 1;
    localparam int F_CMA = 2;
    localparam int F_CPD = 3;
    localparam int F_CPC = 4;
    localparam int F_CPB = 5;
    localparam int F_CPA = 6;

    typedef struct packed {
        logic [CNT_W-1:0]  cmpa;
        logic [CNT_W-1:0]  cmpb;
        logic [CNT_W-1:0]  capa;
        logic [CNT_W-1:0]  capb;
        logic [CNT_W-1:0]  capc;
        logic [CNT_W-1:0]  capd;
        logic [N_FLAG-1:0] flags;
        logic [N_FLAG-1:0] seen;
        logic [N_FLAG-1:0] ien;
        logic              cclr;
        logic [CTRL_W-1:0] ctrl;
    } frt_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } frt_cnt_t;
endpackage

// File: rtl/frt_edge_sync.sv
module frt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic event_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  cur;

    assign cur = s_q.sync[STAGES-1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], pin_i};
        s_d.prev = cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign event_o = rise_sel_i ? (cur & ~s_q.prev) : (~cur & s_q.prev);

    // an edge is seen for one cycle only
    p_single_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_o && $stable(rise_sel_i)) |=> !event_o);
endmodule

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             cclr_i,
    input  logic [CNT_W-1:0] cmpa_i,
    input  logic [CNT_W-1:0] cmpb_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_ev_o,
    output logic             cmpa_ev_o,
    output logic             cmpb_ev_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    frt_cnt_t c_d, c_q;
    logic     hit_a, hit_b, do_clr;

    assign hit_a  = (c_q.cnt == cmpa_i);
    assign hit_b  = (c_q.cnt == cmpb_i);
    assign do_clr = cclr_i && hit_a;

    always_comb begin
        c_d = c_q;
        if (tick_i) begin
            if (do_clr) c_d.cnt = '0;
            else        c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign cnt_o     = c_q.cnt;
    assign ovf_ev_o  = tick_i && (c_q.cnt == CNT_MAX) && !do_clr;
    assign cmpa_ev_o = tick_i && hit_a;
    assign cmpb_ev_o = tick_i && hit_b;

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt_o));
    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !cclr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
    p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_ev_o |=> (cnt_o == '0));
    p_cmp_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmpa_ev_o && cclr_i) |=> (cnt_o == '0));
endmodule

// File: rtl/frt_capture_timer.sv
module frt_capture_timer
    import frt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              standby_i,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N_CAP-1:0]  cap_pin_i,
    output logic              irq_o
);
    frt_regs_t r_d, r_q;

    logic [CNT_W-1:0]  cnt;
    logic              ovf_ev, cmpa_ev, cmpb_ev;
    logic [N_CAP-1:0]  cap_ev;
    logic [N_FLAG-1:0] set_vec, clr_vec;
    logic              st_rd, st_wr;
    logic              buf_a, buf_b;
    logic [DATA_W-1:0] rd_mux;

    assign buf_a = r_q.ctrl[0];
    assign buf_b = r_q.ctrl[1];

    frt_counter u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .cclr_i    (r_q.cclr),
        .cmpa_i    (r_q.cmpa),
        .cmpb_i    (r_q.cmpb),
        .cnt_o     (cnt),
        .ovf_ev_o  (ovf_ev),
        .cmpa_ev_o (cmpa_ev),
        .cmpb_ev_o (cmpb_ev)
    );

    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
        frt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pin_i      (cap_pin_i[g]),
            .rise_sel_i (r_q.ctrl[2+g]),
            .event_o    (cap_ev[g])
        );
    end

    assign st_rd = rd_i && (addr_i == A_STAT);
    assign st_wr = wr_i && (addr_i == A_STAT);

    always_comb begin
        set_vec        = '0;
        set_vec[F_OVF] = ovf_ev;
        set_vec[F_CMB] = cmpb_ev;
        set_vec[F_CMA] = cmpa_ev;
        set_vec[F_CPD] = cap_ev[3];
        set_vec[F_CPC] = cap_ev[2];
        set_vec[F_CPB] = cap_ev[1];
        set_vec[F_CPA] = cap_ev[0];
        clr_vec = st_wr ? (~wdata_i[DATA_W-1:1] & r_q.seen & r_q.flags) : '0;
    end

    always_comb begin
        r_d       = r_q;
        // flags: hardware set dominates a CPU clear
        r_d.flags = (r_q.flags & ~clr_vec) | set_vec;
        r_d.seen  = (r_q.seen | (st_rd ? r_q.flags : '0)) & ~clr_vec & r_d.flags;
        if (st_wr) r_d.cclr = wdata_i[0];

        if (wr_i) begin
            unique case (addr_i)
                A_CMPA_H: r_d.cmpa[CNT_W-1:DATA_W] = wdata_i;
                A_CMPA_L: r_d.cmpa[DATA_W-1:0]     = wdata_i;
                A_CMPB_H: r_d.cmpb[CNT_W-1:DATA_W] = wdata_i;
                A_CMPB_L: r_d.cmpb[DATA_W-1:0]     = wdata_i;
                A_CTRL:   r_d.ctrl                 = wdata_i[CTRL_W-1:0];
                A_IEN:    r_d.ien                  = wdata_i[DATA_W-1:1];
                default: ;
            endcase
        end

        // channel C / D own captures, suppressed in buffered mode
        if (cap_ev[2] && !buf_a) r_d.capc = cnt;
        if (cap_ev[3] && !buf_b) r_d.capd = cnt;
        if (cap_ev[0]) begin
            if (buf_a) r_d.capc = r_q.capa;
            r_d.capa = cnt;
        end
        if (cap_ev[1]) begin
            if (buf_b) r_d.capd = r_q.capb;
            r_d.capb = cnt;
        end

        if (standby_i) begin
            r_d.flags = '0;
            r_d.seen  = '0;
            r_d.cclr  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q      <= '0;
            r_q.cmpa <= {CNT_W{1'b1}};
            r_q.cmpb <= {CNT_W{1'b1}};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CNT_H:  rd_mux = cnt[CNT_W-1:DATA_W];
            A_CNT_L:  rd_mux = cnt[DATA_W-1:0];
            A_CMPA_H: rd_mux = r_q.cmpa[CNT_W-1:DATA_W];
            A_CMPA_L: rd_mux = r_q.cmpa[DATA_W-1:0];
            A_CMPB_H: rd_mux = r_q.cmpb[CNT_W-1:DATA_W];
            A_CMPB_L: rd_mux = r_q.cmpb[DATA_W-1:0];
            A_CAPA_H: rd_mux = r_q.capa[CNT_W-1:DATA_W];
            A_CAPA_L: rd_mux = r_q.capa[DATA_W-1:0];
            A_CAPB_H: rd_mux = r_q.capb[CNT_W-1:DATA_W];
            A_CAPB_L: rd_mux = r_q.capb[DATA_W-1:0];
            A_CAPC_H: rd_mux = r_q.capc[CNT_W-1:DATA_W];
            A_CAPC_L: rd_mux = r_q.capc[DATA_W-1:0];
            A_CAPD_H: rd_mux = r_q.capd[CNT_W-1:DATA_W];
            A_CAPD_L: rd_mux = r_q.capd[DATA_W-1:0];
            A_STAT:   rd_mux = {r_q.flags, r_q.cclr};
            A_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, r_q.ctrl};
            A_IEN:    rd_mux = {r_q.ien, 1'b0};
            default:  rd_mux = '0;
        endcase
    end

    assign rdata_o = rd_i ? rd_mux : '0;
    assign irq_o   = |(r_q.flags & r_q.ien);

    p_hw_set_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec == '0) |=> ((r_q.flags & ~$past(r_q.flags)) == '0));
    p_clear_needs_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_wr && !standby_i) |=> (($past(r_q.flags) & ~r_q.flags) == '0));
    p_clear_needs_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_wr && !standby_i && (r_q.seen == '0)) |=> (($past(r_q.flags) & ~r_q.flags) == '0));
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_vec != '0) && !standby_i) |=> ((r_q.flags & $past(set_vec)) == $past(set_vec)));
    p_cap_plain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_ev[0] && !buf_a) |=> (r_q.capa == $past(cnt)));
    p_cap_shift_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_ev[0] && buf_a) |=> ((r_q.capc == $past(r_q.capa)) && (r_q.capa == $past(cnt))));
    p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.flags & r_q.ien) == '0) |-> !irq_o);
    p_standby_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |=> ({r_q.flags, r_q.cclr} == '0));
endmodule

// File: tb/frt_capture_timer_tb_top.sv
`timescale 1ns/1ps
module frt_capture_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       tick = 1'b0;
    logic [4:0] addr = '0;
    logic       rd_s = 1'b0;
    logic       wr_s = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] pins = '0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] mcnt = '0;
    logic [15:0] mcmpa = 16'hFFFF;
    logic        mcclr = 1'b0;
    logic [15:0] mcap [4];

    always #2 clk = ~clk;

    frt_capture_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .tick_i(tick),
        .addr_i(addr), .rd_i(rd_s), .wr_i(wr_s), .wdata_i(wdata),
        .rdata_o(rdata), .cap_pin_i(pins), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_s = 1'b1;
        @(negedge clk); wr_s = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_s = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_s = 1'b0;
    endtask

    task automatic rd16(input logic [4:0] a, output logic [15:0] d);
        logic [7:0] h, l;
        rd(a, h); rd(a + 5'd1, l);
        d = {h, l};
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mcclr && mcnt == mcmpa) mcnt = '0;
            else                        mcnt = mcnt + 16'd1;
        end
        tick = 1'b0;
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk); pins[ch] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_flags();
        logic [7:0] s;
        rd(5'h0E, s);
        wr(5'h0E, {7'b0, mcclr});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  s;
        logic [15:0] v, v1, v2;
        for (int i = 0; i < 4; i++) mcap[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(5'h0E, s);   chk("R1 status", s, 8'h00);
        rd16(5'h00, v); chk("R1 counter", v, 16'h0000);
        rd16(5'h06, v); chk("R1 capture A", v, 16'h0000);
        rd16(5'h02, v); chk("R1 compare A", v, 16'hFFFF);
        chk("R1 irq", irq, 1'b0);

        // counting and holding
        ticks(37);
        rd16(5'h00, v); chk("R2 count after 37 ticks", v, 16'd37);
        repeat (5) @(negedge clk);
        rd16(5'h00, v); chk("R2 hold without tick", v, 16'd37);

        // full wrap: compares at 0xFFFF also hit
        ticks(65536 - 37);
        rd16(5'h00, v); chk("R3 wrapped count", v, mcnt);
        chk("R3 model wrap", mcnt, 16'h0000);
        wr(5'h0E, 8'h00);
        rd(5'h0E, s); chk("R3 R4 R7 flags kept by blind write", s, 8'h0E);
        wr(5'h0E, 8'h00);
        rd(5'h0E, s); chk("R7 cleared after read", s, 8'h00);
        wr(5'h0E, 8'hFE);
        rd(5'h0E, s); chk("R6 write of ones sets nothing", s, 8'h00);
        wr(5'h0E, 8'h01);
        rd(5'h0E, s); chk("R5 bit0 read/write", s, 8'h01);
        wr(5'h0E, 8'h00);

        // compare-clear period sweep
        mcclr = 1'b1;
        foreach (v1[k]) begin end
        for (int k = 0; k < 5; k++) begin
            int kv;
            kv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 9;
            mcmpa = kv[15:0];
            wr(5'h02, mcmpa[15:8]); wr(5'h03, mcmpa[7:0]);
            wr(5'h0E, 8'h01);
            ticks(3 * (kv + 1) + 2);
            rd16(5'h00, v); chk("R5 clear on compare A", v, mcnt);
            rd(5'h0E, s); chk("R4 compare A flag", s[3], 1'b1);
            wr(5'h0E, 8'h01);
        end
        mcclr = 1'b0;
        wr(5'h0E, 8'h00);
        mcmpa = 16'hFFFF;
        wr(5'h02, 8'hFF); wr(5'h03, 8'hFF);
        clear_flags();

        // set collides with clear
        wr(5'h04, mcnt[15:8]); wr(5'h05, mcnt[7:0]);
        ticks(1);
        rd(5'h0E, s); chk("R4 compare B flag", s, 8'h04);
        wr(5'h04, mcnt[15:8]); wr(5'h05, mcnt[7:0]);
        @(negedge clk); addr = 5'h0E; wdata = 8'h00; wr_s = 1'b1; tick = 1'b1;
        @(negedge clk); wr_s = 1'b0; tick = 1'b0; mcnt = mcnt + 16'd1;
        rd(5'h0E, s); chk("R8 set beats clear", s, 8'h04);

        // interrupt mask
        chk("R11 irq masked", irq, 1'b0);
        wr(5'h10, 8'h04); @(negedge clk);
        chk("R11 irq enabled bit2", irq, 1'b1);
        wr(5'h10, 8'h08); @(negedge clk);
        chk("R11 irq other bit", irq, 1'b0);
        wr(5'h0E, 8'h01);

        // standby
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
        rd(5'h0E, s); chk("R12 standby clears status", s, 8'h00);
        wr(5'h04, 8'hFF); wr(5'h05, 8'hFF);
        wr(5'h10, 8'h00);

        // capture sweep: every channel, both polarities
        for (int ch = 0; ch < 4; ch++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [4:0] ra;
                ra = 5'h06 + 5'(2 * ch);
                wr(5'h0F, pol ? 8'h3C : 8'h00);
                clear_flags();
                ticks(ch * 7 + pol * 3 + 1);
                set_pin(ch, 1'b1);
                if (pol) mcap[ch] = mcnt;
                rd(5'h0E, s); chk("R9 flag after rise", s[7-ch], pol[0]);
                rd16(ra, v);  chk("R9 register after rise", v, mcap[ch]);
                clear_flags();
                ticks(2);
                set_pin(ch, 1'b0);
                if (!pol) mcap[ch] = mcnt;
                rd(5'h0E, s); chk("R9 flag after fall", s[7-ch], !pol[0]);
                rd16(ra, v);  chk("R9 register after fall", v, mcap[ch]);
            end
        end

        // buffered channel A
        wr(5'h0F, 8'h3D);
        clear_flags();
        ticks(3);  v1 = mcnt; set_pin(0, 1'b1); set_pin(0, 1'b0);
        ticks(5);  v2 = mcnt; set_pin(0, 1'b1); set_pin(0, 1'b0);
        rd16(5'h06, v); chk("R10 A holds newest", v, v2);
        rd16(5'h0A, v); chk("R10 C holds previous", v, v1);
        clear_flags();
        ticks(4); set_pin(2, 1'b1); set_pin(2, 1'b0);
        rd(5'h0E, s);   chk("R10 pin C flag in buffer mode", s, 8'h20);
        rd16(5'h0A, v); chk("R10 C kept in buffer mode", v, v1);

        // buffered channel B
        wr(5'h0F, 8'h3E);
        clear_flags();
        ticks(2);  v1 = mcnt; set_pin(1, 1'b1); set_pin(1, 1'b0);
        ticks(6);  v2 = mcnt; set_pin(1, 1'b1); set_pin(1, 1'b0);
        rd16(5'h08, v); chk("R10 B holds newest", v, v2);
        rd16(5'h0C, v); chk("R10 D holds previous", v, v1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule